// File: doc/BRIEF.md
# Doorbell Mailbox Channel Array

This block connects two processing elements with a set of doorbell channels. Each channel carries 32 single-bit flags. The sending element raises flags through a write-one-to-set register in its own register space. The receiving element sees the same flags in its own status register. It can mask each flag, and it retires flags through a write-one-to-clear register. When the receiver retires a flag that is pending, the sender's channel latches a transfer-acknowledge bit. This tells the sender that the doorbell has been taken.

Each side has its own simple register port. The read data is combinational, and a write completes at the next clock edge. Each side folds its per-channel events into four 32-bit combined status words and drives one level interrupt. A per-channel enable gates each channel's contribution. Each side also reads back its frame type, its architecture revision, its supported features and the configured channel count. A single operational-request bit on each side can be written and read back.

The address is an 11-bit word address. When bit 10 is 0, bits 9:0 select a word in the control page. When bit 10 is 1, bits 9:3 select the channel and bits 2:0 select the register inside that channel's window.

Top module: `dbm_mailbox`

## Requirements
- R1: After reset the sender ID word (control word 0, bits 3:0) reads 0 and the receiver ID word reads 1. The architecture word (control word 1) reads 0x20: major revision 2 in bits 7:4, minor 0 in bits 3:0. The feature word (control word 2) reads 1 in bits 3:0. The configuration word (control word 3) reads NUM_CH-1 in bits 7:0. Every receiver mask reads all ones, every flag reads zero and both interrupts are low.
- R2: A sender write to channel register 1 (set) raises the flags where the data has ones and leaves the other flags unchanged. The new flags read back in sender register 0 and receiver register 0 from the cycle after the write. The set register itself reads zero.
- R3: A receiver write to channel register 2 (clear) drops the flags where the data has ones. Receiver register 1 (masked status) reads the flags AND NOT the mask.
- R4: Receiver channel register 4 (mask set) sets mask bits and register 5 (mask clear) clears them, both with write-one semantics. Register 3 reads the mask back.
- R5: A receiver clear that hits at least one pending flag sets the sender's acknowledge bit (sender register 2, bit 0) in the same cycle that the cleared flags first read back as zero. A clear that hits no pending flag leaves the acknowledge bit unchanged.
- R6: Writing a 1 to bit 0 of sender register 3 clears the acknowledge bit. Sender register 4, bit 0, is a readable acknowledge enable, and sender register 5, bit 0, is a readable combined enable.
- R7: The sender's combined status is held in control words 8 to 11. Channel n sits in word 8+n/32, bit n mod 32. It is 1 only while that channel's acknowledge bit, acknowledge enable and combined enable are all set.
- R8: The receiver's combined status uses the same word and bit mapping. Channel n's bit is 1 only while its combined enable (receiver register 6, bit 0) is set and its masked status is nonzero.
- R9: Each side's interrupt is a level that is high exactly while any of that side's combined status bits is set. On the sender it falls once the acknowledge bit is cleared.
- R10: Bit 0 of control word 4 on each side is an operational-request bit. It reads back the value last written and resets to 0.
- R11: Writes to channel windows whose index is NUM_CH or higher change no flag on any channel, and reads from such windows return zero.
- R12: When a sender set and a receiver clear hit the same pending flag in the same cycle, the flag stays set and the acknowledge bit is still raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_wr | input | 1 | Sender write strobe |
| s_addr | input | 11 | Sender word address |
| s_wdata | input | 32 | Sender write data |
| s_rdata | output | 32 | Sender read data (combinational from s_addr) |
| s_irq | output | 1 | Sender combined interrupt (level) |
| r_wr | input | 1 | Receiver write strobe |
| r_addr | input | 11 | Receiver word address |
| r_wdata | input | 32 | Receiver write data |
| r_rdata | output | 32 | Receiver read data (combinational from r_addr) |
| r_irq | output | 1 | Receiver combined interrupt (level) |

## Verification
The bench places a channel above index 31 so that the combined status has to land in the second word. A design that ignored the bank split would light word 8 instead of word 9. It also checks that a clear which misses every pending flag raises no acknowledge, and that an acknowledge without its enable stays out of the combined word. A design that acknowledged every clear write, or that skipped the gating, would show a stray acknowledge bit or a stray interrupt. The bench drives a set and a clear on the same flag in one cycle, where a design that gave the clear precedence would lose the doorbell. It also writes beyond the configured channel count, where truncated decoding would alias the write onto a lower channel.

// File: rtl/dbm_pkg.sv
package dbm_pkg;
   localparam int DATA_W  = 32;
   localparam int ADDR_W  = 11;
   localparam int MAX_CH  = 128;
   localparam int BANKS   = 4;
   localparam int CMB_W   = BANKS * DATA_W;

   localparam logic [3:0] ARCH_MAJOR = 4'd2;
   localparam logic [3:0] FRAME_TX   = 4'd0;
   localparam logic [3:0] FRAME_RX   = 4'd1;

   // control page word offsets
   localparam logic [9:0] CW_ID   = 10'd0;
   localparam logic [9:0] CW_ARCH = 10'd1;
   localparam logic [9:0] CW_FEAT = 10'd2;
   localparam logic [9:0] CW_CFG  = 10'd3;
   localparam logic [9:0] CW_CTRL = 10'd4;
   localparam logic [9:0] CW_CMB0 = 10'd8;

   // sender window registers
   localparam logic [2:0] SW_STAT   = 3'd0;
   localparam logic [2:0] SW_SET    = 3'd1;
   localparam logic [2:0] SW_ACKST  = 3'd2;
   localparam logic [2:0] SW_ACKCLR = 3'd3;
   localparam logic [2:0] SW_ACKEN  = 3'd4;
   localparam logic [2:0] SW_CMBEN  = 3'd5;

   // receiver window registers
   localparam logic [2:0] RW_STAT  = 3'd0;
   localparam logic [2:0] RW_MSTAT = 3'd1;
   localparam logic [2:0] RW_CLR   = 3'd2;
   localparam logic [2:0] RW_MASK  = 3'd3;
   localparam logic [2:0] RW_MSET  = 3'd4;
   localparam logic [2:0] RW_MCLR  = 3'd5;
   localparam logic [2:0] RW_CMBEN = 3'd6;

   typedef struct packed {
      logic       win;
      logic [6:0] ch;
      logic [2:0] idx;
   } addr_t;
endpackage

// File: rtl/dbm_channel.sv
module dbm_channel #(
   parameter int FLAG_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set_we,
   input  logic [FLAG_W-1:0] set_bits,
   input  logic              clr_we,
   input  logic [FLAG_W-1:0] clr_bits,
   input  logic              ack_clr_we,
   input  logic              ack_clr_bit,
   input  logic              ack_en_we,
   input  logic              ack_en_bit,
   input  logic              s_cmb_we,
   input  logic              s_cmb_bit,
   input  logic              mset_we,
   input  logic [FLAG_W-1:0] mset_bits,
   input  logic              mclr_we,
   input  logic [FLAG_W-1:0] mclr_bits,
   input  logic              r_cmb_we,
   input  logic              r_cmb_bit,
   output logic [FLAG_W-1:0] flags,
   output logic [FLAG_W-1:0] mask,
   output logic              ack_st,
   output logic              ack_en,
   output logic              s_cmb_en,
   output logic              r_cmb_en,
   output logic              s_evt,
   output logic              r_evt
);
   logic [FLAG_W-1:0] set_eff, clr_eff;
   logic              clr_hit;

   assign set_eff = set_we ? set_bits : '0;
   assign clr_eff = clr_we ? clr_bits : '0;
   assign clr_hit = |(flags & clr_eff);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags    <= '0;
         mask     <= '1;
         ack_st   <= 1'b0;
         ack_en   <= 1'b0;
         s_cmb_en <= 1'b0;
         r_cmb_en <= 1'b0;
      end else begin
         // a set in the same cycle as a clear keeps the flag
         flags <= (flags & ~clr_eff) | set_eff;
         if (mclr_we) mask <= mask & ~mclr_bits;
         else if (mset_we) mask <= mask | mset_bits;
         if (clr_hit) ack_st <= 1'b1;
         else if (ack_clr_we && ack_clr_bit) ack_st <= 1'b0;
         if (ack_en_we) ack_en   <= ack_en_bit;
         if (s_cmb_we)  s_cmb_en <= s_cmb_bit;
         if (r_cmb_we)  r_cmb_en <= r_cmb_bit;
      end
   end

   assign s_evt = s_cmb_en & ack_st & ack_en;
   assign r_evt = r_cmb_en & (|(flags & ~mask));
endmodule

// File: rtl/dbm_cmb_fold.sv
module dbm_cmb_fold #(
   parameter int NUM_CH = 4
) (
   input  logic [NUM_CH-1:0]         evt,
   output logic [dbm_pkg::CMB_W-1:0] banks,
   output logic                      irq
);
   for (genvar i = 0; i < dbm_pkg::CMB_W; i++) begin : g_bit
      if (i < NUM_CH) begin : g_used
         assign banks[i] = evt[i];
      end else begin : g_pad
         assign banks[i] = 1'b0;
      end
   end
   assign irq = |banks;
endmodule

// File: rtl/dbm_side_regs.sv
module dbm_side_regs #(
   parameter logic [3:0] FRAME     = 4'd0,
   parameter int         NUM_CH    = 4,
   parameter int         MINOR_REV = 0
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr,
   input  logic [9:0]                offs,
   input  logic                      wbit,
   input  logic [dbm_pkg::CMB_W-1:0] cmb,
   output logic [31:0]               rdata
);
   import dbm_pkg::*;
   localparam logic [3:0] MINOR = 4'(MINOR_REV);
   localparam logic [7:0] CFG   = 8'(NUM_CH - 1);

   logic op_req;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) op_req <= 1'b0;
      else if (wr && offs == CW_CTRL) op_req <= wbit;
   end

   always_comb begin
      rdata = '0;
      case (offs)
         CW_ID:       rdata = {28'd0, FRAME};
         CW_ARCH:     rdata = {24'd0, ARCH_MAJOR, MINOR};
         CW_FEAT:     rdata = 32'd1;
         CW_CFG:      rdata = {24'd0, CFG};
         CW_CTRL:     rdata = {31'd0, op_req};
         CW_CMB0:     rdata = cmb[31:0];
         CW_CMB0 + 1: rdata = cmb[63:32];
         CW_CMB0 + 2: rdata = cmb[95:64];
         CW_CMB0 + 3: rdata = cmb[127:96];
         default:     rdata = '0;
      endcase
   end
endmodule

// File: rtl/dbm_mailbox.sv
module dbm_mailbox #(
   parameter int NUM_CH    = 40,
   parameter int FLAG_W    = 32,
   parameter int MINOR_REV = 0
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        s_wr,
   input  logic [10:0] s_addr,
   input  logic [31:0] s_wdata,
   output logic [31:0] s_rdata,
   output logic        s_irq,
   input  logic        r_wr,
   input  logic [10:0] r_addr,
   input  logic [31:0] r_wdata,
   output logic [31:0] r_rdata,
   output logic        r_irq
);
   import dbm_pkg::*;
   localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

   if (NUM_CH < 1 || NUM_CH > MAX_CH) begin : g_bad_ch
      $error("NUM_CH must lie in 1..128");
   end
   if (FLAG_W != DATA_W) begin : g_bad_flag
      $error("FLAG_W must equal the register width");
   end
   if (MINOR_REV < 0 || MINOR_REV > 15) begin : g_bad_minor
      $error("MINOR_REV must fit in four bits");
   end

   addr_t s_a, r_a;
   assign s_a = s_addr;
   assign r_a = r_addr;

   logic s_in, r_in;
   assign s_in = 32'(s_a.ch) < NUM_CH;
   assign r_in = 32'(r_a.ch) < NUM_CH;

   logic [CH_W-1:0] s_ci, r_ci;
   assign s_ci = CH_W'(s_a.ch);
   assign r_ci = CH_W'(r_a.ch);

   logic [NUM_CH-1:0][FLAG_W-1:0] flags, mask;
   logic [NUM_CH-1:0] ack_st, ack_en, s_cmb_en, r_cmb_en, s_evt, r_evt;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic s_sel, r_sel;
      assign s_sel = s_wr & s_a.win & (s_a.ch == 7'(c));
      assign r_sel = r_wr & r_a.win & (r_a.ch == 7'(c));

      dbm_channel #(.FLAG_W(FLAG_W)) u_ch (
         .clk        (clk),
         .rst_n      (rst_n),
         .set_we     (s_sel && s_a.idx == SW_SET),
         .set_bits   (s_wdata),
         .clr_we     (r_sel && r_a.idx == RW_CLR),
         .clr_bits   (r_wdata),
         .ack_clr_we (s_sel && s_a.idx == SW_ACKCLR),
         .ack_clr_bit(s_wdata[0]),
         .ack_en_we  (s_sel && s_a.idx == SW_ACKEN),
         .ack_en_bit (s_wdata[0]),
         .s_cmb_we   (s_sel && s_a.idx == SW_CMBEN),
         .s_cmb_bit  (s_wdata[0]),
         .mset_we    (r_sel && r_a.idx == RW_MSET),
         .mset_bits  (r_wdata),
         .mclr_we    (r_sel && r_a.idx == RW_MCLR),
         .mclr_bits  (r_wdata),
         .r_cmb_we   (r_sel && r_a.idx == RW_CMBEN),
         .r_cmb_bit  (r_wdata[0]),
         .flags      (flags[c]),
         .mask       (mask[c]),
         .ack_st     (ack_st[c]),
         .ack_en     (ack_en[c]),
         .s_cmb_en   (s_cmb_en[c]),
         .r_cmb_en   (r_cmb_en[c]),
         .s_evt      (s_evt[c]),
         .r_evt      (r_evt[c])
      );
   end

   logic [CMB_W-1:0] s_banks, r_banks;

   dbm_cmb_fold #(.NUM_CH(NUM_CH)) u_s_fold (.evt(s_evt), .banks(s_banks), .irq(s_irq));
   dbm_cmb_fold #(.NUM_CH(NUM_CH)) u_r_fold (.evt(r_evt), .banks(r_banks), .irq(r_irq));

   logic [31:0] s_ctrl_rd, r_ctrl_rd;

   dbm_side_regs #(.FRAME(FRAME_TX), .NUM_CH(NUM_CH), .MINOR_REV(MINOR_REV)) u_s_regs (
      .clk(clk), .rst_n(rst_n), .wr(s_wr & ~s_a.win), .offs(s_addr[9:0]),
      .wbit(s_wdata[0]), .cmb(s_banks), .rdata(s_ctrl_rd)
   );
   dbm_side_regs #(.FRAME(FRAME_RX), .NUM_CH(NUM_CH), .MINOR_REV(MINOR_REV)) u_r_regs (
      .clk(clk), .rst_n(rst_n), .wr(r_wr & ~r_a.win), .offs(r_addr[9:0]),
      .wbit(r_wdata[0]), .cmb(r_banks), .rdata(r_ctrl_rd)
   );

   always_comb begin
      s_rdata = '0;
      if (!s_a.win) s_rdata = s_ctrl_rd;
      else if (s_in) begin
         case (s_a.idx)
            SW_STAT:  s_rdata = flags[s_ci];
            SW_ACKST: s_rdata = {31'd0, ack_st[s_ci]};
            SW_ACKEN: s_rdata = {31'd0, ack_en[s_ci]};
            SW_CMBEN: s_rdata = {31'd0, s_cmb_en[s_ci]};
            default:  s_rdata = '0;
         endcase
      end
   end

   always_comb begin
      r_rdata = '0;
      if (!r_a.win) r_rdata = r_ctrl_rd;
      else if (r_in) begin
         case (r_a.idx)
            RW_STAT:  r_rdata = flags[r_ci];
            RW_MSTAT: r_rdata = flags[r_ci] & ~mask[r_ci];
            RW_MASK:  r_rdata = mask[r_ci];
            RW_CMBEN: r_rdata = {31'd0, r_cmb_en[r_ci]};
            default:  r_rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/dbm_mailbox_chk.sv
module dbm_mailbox_chk #(
   parameter int NUM_CH = 4,
   parameter int FLAG_W = 32
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic [NUM_CH-1:0][FLAG_W-1:0] flg,
   input logic [NUM_CH-1:0][FLAG_W-1:0] msk,
   input logic [NUM_CH-1:0]             ack_st,
   input logic [NUM_CH-1:0]             ack_en,
   input logic [NUM_CH-1:0]             s_cmb_en,
   input logic [NUM_CH-1:0]             r_cmb_en,
   input logic                          s_irq,
   input logic                          r_irq
);
   logic [NUM_CH-1:0] rx_act;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_c
      assign rx_act[c] = r_cmb_en[c] & (|(flg[c] & ~msk[c]));

      assert_ack_on_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (|($past(flg[c]) & ~flg[c])) |-> ack_st[c]);

      assert_ack_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(ack_st[c]) |-> $past(|flg[c]));
   end

   assert_mask_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!rst_n) |-> (msk == '1 && flg == '0));

   assert_tx_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
      s_irq == (|(ack_st & ack_en & s_cmb_en)));

   assert_rx_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
      r_irq == (|rx_act));
endmodule

bind dbm_mailbox dbm_mailbox_chk #(.NUM_CH(NUM_CH), .FLAG_W(FLAG_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .flg(flags), .msk(mask), .ack_st(ack_st),
   .ack_en(ack_en), .s_cmb_en(s_cmb_en), .r_cmb_en(r_cmb_en),
   .s_irq(s_irq), .r_irq(r_irq)
);

// File: tb/dbm_mailbox_test.sv
module dbm_mailbox_test;
   localparam int NCH = 40;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        s_wr = 1'b0, r_wr = 1'b0;
   logic [10:0] s_addr = '0, r_addr = '0;
   logic [31:0] s_wdata = '0, r_wdata = '0;
   logic [31:0] s_rdata, r_rdata;
   logic        s_irq, r_irq;

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   dbm_mailbox #(.NUM_CH(NCH)) uut (
      .clk(clk), .rst_n(rst_n),
      .s_wr(s_wr), .s_addr(s_addr), .s_wdata(s_wdata), .s_rdata(s_rdata), .s_irq(s_irq),
      .r_wr(r_wr), .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata), .r_irq(r_irq)
   );

   function automatic logic [10:0] win(input int ch, input int rg);
      return {1'b1, 7'(ch), 3'(rg)};
   endfunction
   function automatic logic [10:0] cw(input int w);
      return {1'b0, 10'(w)};
   endfunction

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s got=%h exp=%h", tag, got, exp);
      end
   endtask

   task automatic s_write(input logic [10:0] a, input logic [31:0] d);
      @(negedge clk); s_addr = a; s_wdata = d; s_wr = 1'b1;
      @(negedge clk); s_wr = 1'b0;
   endtask
   task automatic r_write(input logic [10:0] a, input logic [31:0] d);
      @(negedge clk); r_addr = a; r_wdata = d; r_wr = 1'b1;
      @(negedge clk); r_wr = 1'b0;
   endtask
   task automatic s_read(input logic [10:0] a, output logic [31:0] d);
      @(negedge clk); s_addr = a; #1 d = s_rdata;
   endtask
   task automatic r_read(input logic [10:0] a, output logic [31:0] d);
      @(negedge clk); r_addr = a; #1 d = r_rdata;
   endtask

   task automatic t_reset;
      logic [31:0] d;
      s_read(cw(0), d); check("R1 sender id", d, 32'd0);
      r_read(cw(0), d); check("R1 receiver id", d, 32'd1);
      s_read(cw(1), d); check("R1 arch", d, 32'h20);
      r_read(cw(2), d); check("R1 feature", d, 32'd1);
      s_read(cw(3), d); check("R1 config", d, NCH - 1);
      r_read(win(0, 3), d); check("R1 mask ch0", d, 32'hFFFF_FFFF);
      r_read(win(NCH - 1, 3), d); check("R1 mask last", d, 32'hFFFF_FFFF);
      s_read(win(0, 0), d); check("R1 flags", d, 32'd0);
      check("R1 irqs", {30'd0, s_irq, r_irq}, 32'd0);
   endtask

   task automatic t_set;
      logic [31:0] d;
      s_write(win(0, 1), 32'h5);
      s_read(win(0, 0), d); check("R2 sender status", d, 32'h5);
      r_read(win(0, 0), d); check("R2 receiver status", d, 32'h5);
      s_read(win(0, 1), d); check("R2 set reads zero", d, 32'h0);
      s_write(win(0, 1), 32'h8);
      r_read(win(0, 0), d); check("R2 zeros keep flags", d, 32'hD);
   endtask

   task automatic t_mask;
      logic [31:0] d;
      r_read(win(0, 1), d); check("R3 masked all", d, 32'h0);
      r_write(win(0, 5), 32'h1);
      r_read(win(0, 3), d); check("R4 mask clear", d, 32'hFFFF_FFFE);
      r_read(win(0, 1), d); check("R3 masked status", d, 32'h1);
      r_write(win(0, 4), 32'h1);
      r_read(win(0, 3), d); check("R4 mask set", d, 32'hFFFF_FFFF);
   endtask

   task automatic t_clear_ack;
      logic [31:0] d;
      s_write(win(0, 4), 32'h1);
      s_read(win(0, 4), d); check("R6 ack enable", d, 32'h1);
      @(negedge clk); r_addr = win(0, 2); r_wdata = 32'h4; r_wr = 1'b1;
      @(negedge clk); r_wr = 1'b0; s_addr = win(0, 2); r_addr = win(0, 0);
      #1;
      check("R5 ack same cycle", s_rdata, 32'h1);
      check("R3 cleared", r_rdata, 32'h9);
      s_write(win(0, 3), 32'h1);
      s_read(win(0, 2), d); check("R6 ack cleared", d, 32'h0);
      r_write(win(0, 2), 32'h2);
      s_read(win(0, 2), d); check("R5 no hit no ack", d, 32'h0);
      r_write(win(0, 2), 32'h9);
      s_read(win(0, 0), d); check("R5 sender sees zero", d, 32'h0);
      s_read(win(0, 2), d); check("R5 ack on hit", d, 32'h1);
      check("R7 no cmb without enable", {31'd0, s_irq}, 32'd0);
      s_write(win(0, 3), 32'h1);
   endtask

   task automatic t_tx_combined;
      logic [31:0] d;
      s_write(win(33, 5), 32'h1);
      s_read(win(33, 5), d); check("R6 cmb enable", d, 32'h1);
      s_write(win(33, 1), 32'h10);
      r_write(win(33, 2), 32'h10);
      s_read(cw(9), d); check("R7 ack without enable", d, 32'h0);
      s_write(win(33, 4), 32'h1);
      s_read(cw(9), d); check("R7 bank1 bit1", d, 32'h2);
      s_read(cw(8), d); check("R7 bank0 empty", d, 32'h0);
      check("R9 tx irq high", {31'd0, s_irq}, 32'd1);
      s_write(win(33, 3), 32'h1);
      check("R9 tx irq low", {31'd0, s_irq}, 32'd0);
      s_read(cw(9), d); check("R7 bank cleared", d, 32'h0);
   endtask

   task automatic t_rx_combined;
      logic [31:0] d;
      r_write(win(2, 6), 32'h1);
      s_write(win(2, 1), 32'h80);
      check("R8 masked no irq", {31'd0, r_irq}, 32'd0);
      r_write(win(2, 5), 32'h80);
      r_read(cw(8), d); check("R8 rx bank", d, 32'h4);
      check("R9 rx irq high", {31'd0, r_irq}, 32'd1);
      r_write(win(2, 2), 32'h80);
      check("R9 rx irq low", {31'd0, r_irq}, 32'd0);
      s_write(win(2, 3), 32'h1);
   endtask

   task automatic t_opreq;
      logic [31:0] d;
      s_read(cw(4), d); check("R10 reset zero", d, 32'h0);
      s_write(cw(4), 32'h1);
      s_read(cw(4), d); check("R10 sender readback", d, 32'h1);
      r_write(cw(4), 32'h1);
      r_read(cw(4), d); check("R10 receiver readback", d, 32'h1);
      r_write(cw(4), 32'h0);
      r_read(cw(4), d); check("R10 receiver cleared", d, 32'h0);
   endtask

   task automatic t_range;
      logic [31:0] d;
      s_write(win(45, 1), 32'hFFFF_FFFF);
      s_read(win(45, 0), d); check("R11 oob read zero", d, 32'h0);
      r_read(win(45, 3), d); check("R11 oob mask zero", d, 32'h0);
      s_read(win(13, 0), d); check("R11 no alias 13", d, 32'h0);
      s_read(win(5, 0), d); check("R11 no alias 5", d, 32'h0);
      r_read(win(NCH - 1, 0), d); check("R11 last ch clean", d, 32'h0);
   endtask

   task automatic t_same_cycle;
      logic [31:0] d;
      s_write(win(1, 1), 32'h8);
      @(negedge clk);
      s_addr = win(1, 1); s_wdata = 32'h8; s_wr = 1'b1;
      r_addr = win(1, 2); r_wdata = 32'h8; r_wr = 1'b1;
      @(negedge clk); s_wr = 1'b0; r_wr = 1'b0;
      r_read(win(1, 0), d); check("R12 set wins", d, 32'h8);
      s_read(win(1, 2), d); check("R12 ack raised", d, 32'h1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_set();
      t_mask();
      t_clear_ack();
      t_tx_combined();
      t_rx_combined();
      t_opreq();
      t_range();
      t_same_cycle();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog got=hung exp=done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule